// File: doc/BRIEF.md
# Address Region Decoder with Wait-State Sequencer

This block sits between a CPU address bus and the memories behind it. When a request is accepted, it classifies the 32-bit byte address into one of four fixed windows. The windows are on-chip boot RAM, 16-bit external static memory, 8-bit external static memory and on-chip I/O registers. Only the five most significant address bits are used, because every window is aligned to 128 MB.

Once the address is classified, a counter holds the access open for the wait-state count of that window. It then raises a completion pulse. During the whole access a one-hot select names the window, and a direction flag carries the captured read/write indication. For I/O accesses the block also presents the word address, which is the byte address without its two lowest bits. An address that falls in no window selects nothing and still completes in one cycle, so the requester cannot hang. Such an access also sets a sticky debug flag.

Top module: `region_wait_decoder`

## Requirements
- R1: An address whose bits 31..27 equal 5'b10111 (0xB8000000 to 0xBFFFFFFF) selects boot RAM on `sel_o[0]` and completes with WAIT_BOOT (default 0) wait states.
- R2: An address whose bits 31..27 equal 5'b00000 or 5'b10000 (0x00000000 to 0x07FFFFFF, or 0x80000000 to 0x87FFFFFF) selects 16-bit static memory on `sel_o[1]` and completes with WAIT_EXT16 (default 2) wait states.
- R3: An address whose bits 31..27 equal 5'b10110 (0xB0000000 to 0xB7FFFFFF) selects 8-bit static memory on `sel_o[2]` and completes with WAIT_EXT8 (default 7) wait states.
- R4: An address whose bits 31..27 equal 5'b00100 (0x20000000 to 0x27FFFFFF) selects I/O on `sel_o[3]` and always completes with zero wait states. While that access is open, `io_addr_o` equals address bits 31..2. At all other times `io_addr_o` is zero.
- R5: Any other address drives `sel_o` to zero and completes with zero wait states. It sets `unmapped_o` from the cycle after acceptance, and the flag stays set until reset.
- R6: `sel_o` has at most one bit set. It holds its value from the cycle after acceptance through the `done_o` cycle, and it is zero whenever no access is open.
- R7: A request is accepted on a rising edge where `req_i` is high and no access is open. `done_o` is then high for exactly one cycle, namely the cycle that begins N edges after the accepting edge, where N is the wait count of the window. Requests raised while an access is open, including its `done_o` cycle, are ignored.
- R8: `wr_o` equals the `wr_i` value captured at acceptance for the whole access, and it is zero when no access is open.
- R9: While `rst_n` is low, `sel_o`, `done_o`, `wr_o`, `io_addr_o` and `unmapped_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request strobe |
| addr_i | input | ADDR_W (32) | CPU byte address |
| wr_i | input | 1 | 1 = write, 0 = read |
| sel_o | output | 4 | One-hot window select: 0 boot RAM, 1 16-bit static, 2 8-bit static, 3 I/O |
| done_o | output | 1 | Single-cycle completion pulse |
| wr_o | output | 1 | Direction of the open access |
| io_addr_o | output | ADDR_W-2 (30) | I/O word address during an I/O access |
| unmapped_o | output | 1 | Sticky unmapped-access flag |

## Verification
The assertions check several properties on every cycle:
- `sel_o` is one-hot or zero.
- `sel_o` and `wr_o` stay stable through an open access.
- `done_o` never lasts longer than one cycle.
- I/O and unmapped requests complete on the next cycle.
- The unmapped flag never drops.
- The distance from acceptance to `done_o` matches the wait count of the window, measured with a counter.

Other behaviours can only be shown by the bench's scenarios. These are that each address window lands on the right select bit, that the edges of the windows fall where the map puts them, and that requests issued during an access really leave the sequence untouched. The same applies to the I/O word address value and to reset clearing the sticky flag.

// File: rtl/rgn_pkg.sv
package rgn_pkg;

  typedef enum logic [1:0] {
    RG_BOOT  = 2'd0,
    RG_EXT16 = 2'd1,
    RG_EXT8  = 2'd2,
    RG_IO    = 2'd3
  } rgn_e;

  localparam int RG_COUNT = 4;
  localparam int TAG_W    = 5;

  typedef struct packed {
    logic hit;
    rgn_e rgn;
  } rgn_dec_t;

  // classify the top address bits; every window spans 128 MB
  function automatic rgn_dec_t rgn_classify(input logic [TAG_W-1:0] tag);
    rgn_dec_t d;
    d.hit = 1'b1;
    d.rgn = RG_BOOT;
    unique case (tag)
      5'b10111: d.rgn = RG_BOOT;
      5'b00000,
      5'b10000: d.rgn = RG_EXT16;
      5'b10110: d.rgn = RG_EXT8;
      5'b00100: d.rgn = RG_IO;
      default:  d.hit = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/rgn_decode.sv
module rgn_decode
  import rgn_pkg::*;
#(
  parameter int CNT_W      = 3,
  parameter int WAIT_BOOT  = 0,
  parameter int WAIT_EXT16 = 2,
  parameter int WAIT_EXT8  = 7
) (
  input  logic [TAG_W-1:0] tag_i,
  output rgn_e             rgn_o,
  output logic             hit_o,
  output logic [CNT_W-1:0] wait_o
);

  rgn_dec_t dec;

  always_comb begin
    dec    = rgn_classify(tag_i);
    rgn_o  = dec.rgn;
    hit_o  = dec.hit;
    wait_o = '0;
    if (dec.hit) begin
      unique case (dec.rgn)
        RG_BOOT:  wait_o = CNT_W'(WAIT_BOOT);
        RG_EXT16: wait_o = CNT_W'(WAIT_EXT16);
        RG_EXT8:  wait_o = CNT_W'(WAIT_EXT8);
        RG_IO:    wait_o = '0;  // I/O never stalls
        default:  wait_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/rgn_seq.sv
module rgn_seq #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] wait_i,
  output logic             busy_o,
  output logic             done_o
);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        cnt_d  = wait_i;
      end
    end else if (cnt_q == '0) begin
      busy_d = 1'b0;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

endmodule

// File: rtl/region_wait_decoder.sv
module region_wait_decoder
  import rgn_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WAIT_BOOT  = 0,
  parameter int WAIT_EXT16 = 2,
  parameter int WAIT_EXT8  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  output logic [3:0]        sel_o,
  output logic              done_o,
  output logic              wr_o,
  output logic [ADDR_W-3:0] io_addr_o,
  output logic              unmapped_o
);

  localparam int IOA_W  = ADDR_W - 2;
  localparam int MAX_AB = (WAIT_BOOT > WAIT_EXT16) ? WAIT_BOOT : WAIT_EXT16;
  localparam int MAX_W  = (MAX_AB > WAIT_EXT8) ? MAX_AB : WAIT_EXT8;
  localparam int CNT_W  = (MAX_W < 1) ? 1 : $clog2(MAX_W + 1);

  logic [TAG_W-1:0] tag;
  rgn_e             dec_rgn;
  logic             dec_hit;
  logic [CNT_W-1:0] dec_wait;
  logic             busy;
  logic             accept;
  logic             unused_lsb;

  rgn_e             rgn_q, rgn_d;
  logic             hit_q, hit_d;
  logic             wr_q, wr_d;
  logic [IOA_W-1:0] ioa_q, ioa_d;
  logic             unm_q, unm_d;

  assign tag        = addr_i[ADDR_W-1 -: TAG_W];
  assign unused_lsb = ^addr_i[1:0];

  rgn_decode #(
    .CNT_W      (CNT_W),
    .WAIT_BOOT  (WAIT_BOOT),
    .WAIT_EXT16 (WAIT_EXT16),
    .WAIT_EXT8  (WAIT_EXT8)
  ) u_dec (
    .tag_i  (tag),
    .rgn_o  (dec_rgn),
    .hit_o  (dec_hit),
    .wait_o (dec_wait)
  );

  assign accept = req_i && !busy;

  rgn_seq #(
    .CNT_W (CNT_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (accept),
    .wait_i  (dec_wait),
    .busy_o  (busy),
    .done_o  (done_o)
  );

  // capture stage: next-state logic with explicit enable
  always_comb begin
    rgn_d = rgn_q;
    hit_d = hit_q;
    wr_d  = wr_q;
    ioa_d = ioa_q;
    unm_d = unm_q;
    if (accept) begin
      rgn_d = dec_rgn;
      hit_d = dec_hit;
      wr_d  = wr_i;
      ioa_d = addr_i[ADDR_W-1:2];
      if (!dec_hit) unm_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgn_q <= RG_BOOT;
      hit_q <= 1'b0;
      wr_q  <= 1'b0;
      ioa_q <= '0;
      unm_q <= 1'b0;
    end else begin
      rgn_q <= rgn_d;
      hit_q <= hit_d;
      wr_q  <= wr_d;
      ioa_q <= ioa_d;
      unm_q <= unm_d;
    end
  end

  for (genvar g = 0; g < RG_COUNT; g++) begin : g_sel
    assign sel_o[g] = busy && hit_q && (rgn_q == rgn_e'(g));
  end

  assign io_addr_o  = (busy && hit_q && (rgn_q == RG_IO)) ? ioa_q : '0;
  assign wr_o       = busy && wr_q;
  assign unmapped_o = unm_q;

endmodule

// File: rtl/rgn_chk.sv
module rgn_chk #(
  parameter int WAIT_BOOT  = 0,
  parameter int WAIT_EXT16 = 2,
  parameter int WAIT_EXT8  = 7
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_i,
  input logic [4:0] tag,
  input logic       busy,
  input logic [3:0] sel_o,
  input logic       done_o,
  input logic       wr_o,
  input logic       unmapped_o
);

  logic   take;
  logic   tag_io, tag_unm;
  int     elapsed;
  int     exp_len;
  int     tag_len;

  assign take    = req_i && !busy;
  assign tag_io  = (tag == 5'h04);
  assign tag_unm = !(tag == 5'h17 || tag == 5'h00 || tag == 5'h10 ||
                     tag == 5'h16 || tag == 5'h04);

  always_comb begin
    if (tag == 5'h17)                      tag_len = WAIT_BOOT;
    else if (tag == 5'h00 || tag == 5'h10) tag_len = WAIT_EXT16;
    else if (tag == 5'h16)                 tag_len = WAIT_EXT8;
    else                                   tag_len = 0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= 0;
      exp_len <= 0;
    end else if (take) begin
      elapsed <= 0;
      exp_len <= tag_len;
    end else if (busy && !done_o) begin
      elapsed <= elapsed + 1;
    end
  end

  assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_o));

  assert_sel_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_o) |=> $stable(sel_o));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_wait_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (elapsed == exp_len));

  assert_io_nowait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && tag_io) |=> (done_o && sel_o == 4'b1000));

  assert_unm_fast_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && tag_unm) |=> (done_o && unmapped_o && sel_o == 4'b0000));

  assert_unm_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_o |=> unmapped_o);

  assert_wr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_o) |=> $stable(wr_o));

endmodule

bind region_wait_decoder rgn_chk #(
  .WAIT_BOOT  (WAIT_BOOT),
  .WAIT_EXT16 (WAIT_EXT16),
  .WAIT_EXT8  (WAIT_EXT8)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .tag        (addr_i[ADDR_W-1 -: 5]),
  .busy       (busy),
  .sel_o      (sel_o),
  .done_o     (done_o),
  .wr_o       (wr_o),
  .unmapped_o (unmapped_o)
);

// File: tb/tb_region_wait_decoder.sv
module tb_region_wait_decoder;

  logic        clk;
  logic        rst_n;
  logic        req_i;
  logic [31:0] addr_i;
  logic        wr_i;
  logic [3:0]  sel_o;
  logic        done_o;
  logic        wr_o;
  logic [29:0] io_addr_o;
  logic        unmapped_o;

  int  n_chk;
  int  n_fail;
  bit  sticky;
  bit  finished;

  region_wait_decoder dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .addr_i     (addr_i),
    .wr_i       (wr_i),
    .sel_o      (sel_o),
    .done_o     (done_o),
    .wr_o       (wr_o),
    .io_addr_o  (io_addr_o),
    .unmapped_o (unmapped_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // 0 boot, 1 ext16, 2 ext8, 3 io, 4 unmapped
  function automatic int kind_of(input logic [31:0] a);
    case (a[31:27])
      5'b10111:          return 0;
      5'b00000, 5'b10000: return 1;
      5'b10110:          return 2;
      5'b00100:          return 3;
      default:           return 4;
    endcase
  endfunction

  function automatic int wait_of(input int k);
    case (k)
      1:       return 2;
      2:       return 7;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(input int k);
    case (k)
      0:       return "R1";
      1:       return "R2";
      2:       return "R3";
      3:       return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic check_idle(input string rq);
    chk(sel_o == 4'b0,  rq, "idle sel", 64'(sel_o), 0);
    chk(done_o == 1'b0, rq, "idle done", 64'(done_o), 0);
    chk(wr_o == 1'b0,   rq, "idle wr", 64'(wr_o), 0);
    chk(io_addr_o == '0, rq, "idle io_addr", 64'(io_addr_o), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_i = 1'b0;
    @(negedge clk);
    // R9: outputs held at zero during reset
    check_idle("R9");
    chk(unmapped_o == 1'b0, "R9", "reset unmapped", 64'(unmapped_o), 0);
    sticky = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic access(input logic [31:0] a, input bit w, input bit junk);
    int k, n;
    logic [3:0] es;
    k  = kind_of(a);
    n  = wait_of(k);
    es = (k < 4) ? 4'(1 << k) : 4'b0;
    @(negedge clk);
    req_i  = 1'b1;
    addr_i = a;
    wr_i   = w;
    @(negedge clk);
    if (k == 4) sticky = 1'b1;
    for (int j = 0; j <= n; j++) begin
      if (junk) begin
        // R7: requests while the access is open must be ignored
        req_i  = 1'b1;
        addr_i = $urandom;
        wr_i   = ~w;
      end else begin
        req_i = 1'b0;
      end
      chk(sel_o == es, req_of(k), "sel", 64'(sel_o), 64'(es));
      chk(done_o == (j == n), "R7", "done timing", 64'(done_o), 64'(j == n));
      chk(wr_o == w, "R8", "wr", 64'(wr_o), 64'(w));
      chk(io_addr_o == ((k == 3) ? a[31:2] : 30'b0), "R4", "io_addr",
          64'(io_addr_o), 64'((k == 3) ? a[31:2] : 30'b0));
      chk(unmapped_o == sticky, "R5", "unmapped flag", 64'(unmapped_o), 64'(sticky));
      if (j < n) @(negedge clk);
    end
    req_i = 1'b0;
    @(negedge clk);
    // R6: nothing selected once the access is closed
    check_idle("R6");
  endtask

  function automatic logic [31:0] rand_addr();
    logic [4:0] t;
    case ($urandom % 7)
      0: t = 5'b10111;
      1: t = 5'b00000;
      2: t = 5'b10000;
      3: t = 5'b10110;
      4: t = 5'b00100;
      default: t = 5'($urandom);
    endcase
    return {t, 27'($urandom)};
  endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D0C_5EED));
    n_chk = 0; n_fail = 0; sticky = 0; finished = 0;
    rst_n = 1'b0; req_i = 1'b0; addr_i = '0; wr_i = 1'b0;
    do_reset();

    // directed window edges
    access(32'hB800_0000, 1'b0, 1'b0);  // R1
    access(32'hBFFF_FFFF, 1'b1, 1'b0);  // R1
    access(32'h0000_0000, 1'b1, 1'b0);  // R2 low window
    access(32'h07FF_FFFC, 1'b0, 1'b0);  // R2
    access(32'h8000_0004, 1'b1, 1'b0);  // R2 high window
    access(32'hB000_0000, 1'b0, 1'b0);  // R3
    access(32'hB7FF_FFFF, 1'b1, 1'b1);  // R3 with R7 junk requests
    access(32'h2000_0008, 1'b1, 1'b0);  // R4
    access(32'h27FF_FFFF, 1'b0, 1'b1);  // R4
    chk(unmapped_o == 1'b0, "R5", "flag clear before unmapped", 64'(unmapped_o), 0);
    access(32'h0800_0000, 1'b0, 1'b0);  // R5 just past ext16
    access(32'h2800_0000, 1'b1, 1'b0);  // R5
    access(32'hB800_0000, 1'b0, 1'b1);  // R5 sticky across mapped access
    do_reset();                         // R9 clears sticky
    access(32'h8000_0000, 1'b1, 1'b1);

    for (int i = 0; i < 400; i++) begin
      access(rand_addr(), 1'($urandom), 1'($urandom));
      if (i == 200) do_reset();
    end

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule